// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of one synchronous DRAM burst. A read or write command delivers a starting column. Two fields travel with it: a length code and an order bit. From the clock edge that samples the command, the block issues one 9-bit column per cycle and raises a flag on the final beat. All addresses of a burst stay inside the column segment that is aligned to the burst length. Only the low bits move. In sequential order they count upward and wrap. In interleaved order they are the starting low bits XORed with the beat number.

A new command may arrive on any cycle. It abandons whatever is left of the current burst and starts a full-length burst from its own column. A stop input ends the current burst at once. The mode fields are sampled only with a command, so changes to them during a burst have no effect.

The output is a plain valid-qualified stream with no ready input. The memory array accepts one column per clock, so the stream has no back-pressure: a consumer must take every column in the cycle it is valid.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and while no burst is running, `col_valid_o` and `col_last_o` are low.
- R2: The length code selects the number of beats: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. `col_valid_o` is high for exactly that many consecutive cycles. The first of those cycles follows the clock edge that samples `cmd_valid_i`.
- R3: When `cmd_interleave_i` = 0 (sequential order), beat n carries low log2(BL) bits equal to (start + n) mod BL.
- R4: When `cmd_interleave_i` = 1 (interleaved order), beat n carries low log2(BL) bits equal to start XOR n.
- R5: On every beat, the column bits at and above bit log2(BL) equal those of the starting column, so the burst never leaves its aligned segment.
- R6: `col_last_o` is high on beat BL-1 of a burst and on no other cycle.
- R7: A command accepted while a burst is running restarts the sequence. In the next cycle the output is beat 0 of the new command, which then runs for its own full length.
- R8: `stop_i` makes `col_valid_o` low in the following cycle. It has no effect when no burst is running. If `stop_i` and `cmd_valid_i` are high in the same cycle, the command wins.
- R9: A reserved length code (100 to 111) is treated as a burst of length 1.
- R10: With a length-8 interleaved burst from column 2, the low three bits follow the order 2, 3, 0, 1, 6, 7, 4, 5.
- R11: The column, length code and order bit are sampled only when `cmd_valid_i` is high. Changing them during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Read or write command accepted this cycle |
| cmd_col_i | input | 9 | Starting column of the command |
| cmd_len_code_i | input | 3 | Burst length code |
| cmd_interleave_i | input | 1 | Order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst stop |
| col_valid_o | output | 1 | A column is issued this cycle |
| col_o | output | 9 | Column address of the current beat |
| col_last_o | output | 1 | Current beat is the last of the burst |

## Verification
The assertions check the following on every cycle:
- the beat count never passes the latched length;
- a final beat with no new command is followed by an idle cycle;
- a stop with no command empties the generator;
- a command always starts at beat 0;
- the upper column bits stay fixed from one beat to the next;
- a reserved code ends after a single beat.

The actual address orders need the bench's scenarios. It sweeps every starting column under every length code and both orders, and compares each beat with an arithmetic model. That includes the wrap inside the segment, the first-beat position of the last flag and the fixed interleaved example. The bench also shows restart mid-burst, stop with and without a burst running, the command-beats-stop rule, and that mode inputs changed during a burst have no effect.

// File: rtl/burst_col_gen_pkg.sv
package burst_col_gen_pkg;
  typedef enum logic {
    ORD_SEQUENTIAL  = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 3,
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LOG_W-1:0]  len_log_o,
  output logic              reserved_o
);
  always_comb begin
    if (code_i > CODE_W'(MAX_LOG)) begin
      reserved_o = 1'b1;
      len_log_o  = '0;
    end else begin
      reserved_o = 1'b0;
      len_log_o  = code_i[LOG_W-1:0];
    end
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int MAX_LOG = 3,
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               stop_i,
  input  logic [LOG_W-1:0]   len_log_i,
  output logic               active_o,
  output logic [MAX_LOG-1:0] beat_o,
  output logic [LOG_W-1:0]   len_log_o,
  output logic               last_o
);
  logic [MAX_LOG-1:0] final_beat;

  assign final_beat = {MAX_LOG{1'b1}} >> (MAX_LOG - int'(len_log_o));
  assign last_o     = active_o && (beat_o == final_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      beat_o    <= '0;
      len_log_o <= '0;
    end else if (load_i) begin
      active_o  <= 1'b1;
      beat_o    <= '0;
      len_log_o <= len_log_i;
    end else if (stop_i || last_o) begin
      active_o  <= 1'b0;
      beat_o    <= '0;
    end else if (active_o) begin
      beat_o    <= beat_o + 1'b1;
    end
  end

  // R7: a command always starts from beat zero
  p_load_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o && beat_o == '0));

  // R6: the final beat without a new command leaves the generator idle
  p_last_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !load_i) |=> !active_o);

  // R8: stop without a command empties the generator
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> !active_o);

  // R2: the beat count never passes the latched length
  p_beat_in_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (beat_o <= final_beat));
endmodule

// File: rtl/bcg_addr_form.sv
module bcg_addr_form
  import burst_col_gen_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int MAX_LOG = 3,
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic [COL_W-1:0]   base_i,
  input  burst_order_e       order_i,
  input  logic [MAX_LOG-1:0] beat_i,
  input  logic [LOG_W-1:0]   len_log_i,
  output logic [COL_W-1:0]   col_o
);
  logic [MAX_LOG-1:0] seq_low;
  logic [MAX_LOG-1:0] intl_low;

  assign seq_low  = base_i[MAX_LOG-1:0] + beat_i;
  assign intl_low = base_i[MAX_LOG-1:0] ^ beat_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < MAX_LOG) begin : g_low
      logic in_seg;
      assign in_seg   = (i < int'(len_log_i));
      assign col_o[i] = !in_seg ? base_i[i] :
                        (order_i == ORD_INTERLEAVED) ? intl_low[i] : seq_low[i];
    end else begin : g_high
      assign col_o[i] = base_i[i];
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_gen_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic [CODE_W-1:0] cmd_len_code_i,
  input  logic              cmd_interleave_i,
  input  logic              stop_i,
  output logic              col_valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic              col_last_o
);
  localparam int LOG_W = $clog2(MAX_LOG + 1);

  logic [LOG_W-1:0]   dec_len_log;
  logic               dec_reserved;
  logic [LOG_W-1:0]   cur_len_log;
  logic [MAX_LOG-1:0] cur_beat;
  logic [COL_W-1:0]   base_q;
  burst_order_e       order_q;

  bcg_len_decode #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_dec (
    .code_i     (cmd_len_code_i),
    .len_log_o  (dec_len_log),
    .reserved_o (dec_reserved)
  );

  bcg_beat_ctr #(.MAX_LOG(MAX_LOG)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cmd_valid_i),
    .stop_i    (stop_i),
    .len_log_i (dec_len_log),
    .active_o  (col_valid_o),
    .beat_o    (cur_beat),
    .len_log_o (cur_len_log),
    .last_o    (col_last_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_SEQUENTIAL;
    end else if (cmd_valid_i) begin
      base_q  <= cmd_col_i;
      order_q <= burst_order_e'(cmd_interleave_i);
    end
  end

  bcg_addr_form #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_form (
    .base_i    (base_q),
    .order_i   (order_q),
    .beat_i    (cur_beat),
    .len_log_i (cur_len_log),
    .col_o     (col_o)
  );

  // R9: a reserved length code runs for a single beat
  p_reserved_len1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && dec_reserved) |=> (col_valid_o && col_last_o));

  // R5: upper column bits hold from beat to beat within one burst
  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && !cmd_valid_i) |=>
      (!col_valid_o || col_o[COL_W-1:MAX_LOG] == $past(col_o[COL_W-1:MAX_LOG])));
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [8:0] cmd_col = '0;
  logic [2:0] cmd_code = '0;
  logic       cmd_intl = 1'b0;
  logic       stop = 1'b0;
  logic       col_valid;
  logic [8:0] col;
  logic       col_last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_col_i(cmd_col),
    .cmd_len_code_i(cmd_code), .cmd_interleave_i(cmd_intl), .stop_i(stop),
    .col_valid_o(col_valid), .col_o(col), .col_last_o(col_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input int code);
    return (code < 4) ? (1 << code) : 1;
  endfunction

  function automatic int exp_col(input int s, input int t, input int code, input int n);
    int len, mask, low;
    len  = len_of(code);
    mask = len - 1;
    low  = t ? ((s ^ n) & mask) : ((s + n) & mask);
    return (s & ~mask) | low;
  endfunction

  task automatic drive_cmd(input int s, input int t, input int code);
    cmd_valid = 1'b1;
    cmd_col   = 9'(s);
    cmd_intl  = t[0];
    cmd_code  = 3'(code);
  endtask

  // One full burst; checks every beat, then the idle cycle after it
  task automatic run_burst(input int s, input int t, input int code);
    int len;
    len = len_of(code);
    @(negedge clk);
    drive_cmd(s, t, code);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_col   = ~cmd_col;          // R11: scramble mode inputs mid-burst
    cmd_intl  = ~cmd_intl;
    cmd_code  = cmd_code + 3'd1;
    for (int n = 0; n < len; n++) begin
      chk(col_valid == 1'b1, "R2 valid during burst", int'(col_valid), 1);
      chk(int'(col) == exp_col(s, t, code, n),
          t ? "R4/R5/R11 interleaved column" : "R3/R5/R11 sequential column",
          int'(col), exp_col(s, t, code, n));
      chk(col_last == (n == len - 1), "R6 last flag", int'(col_last), int'(n == len - 1));
      @(negedge clk);
    end
    chk(col_valid == 1'b0, "R2 idle after burst", int'(col_valid), 0);
  endtask

  initial begin
    int r10_seq[8] = '{2, 3, 0, 1, 6, 7, 4, 5};
    repeat (3) @(negedge clk);
    chk(col_valid == 1'b0 && col_last == 1'b0, "R1 reset state", int'(col_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_valid == 1'b0, "R1 idle after reset", int'(col_valid), 0);

    // R10: fixed interleaved example, start column 2, length 8
    @(negedge clk);
    drive_cmd(2, 1, 3);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int n = 0; n < 8; n++) begin
      chk(int'(col[2:0]) == r10_seq[n], "R10 interleaved example", int'(col[2:0]), r10_seq[n]);
      @(negedge clk);
    end

    // Exhaustive sweep: all columns, all codes (R9 reserved ones), both orders
    for (int code = 0; code < 8; code++)
      for (int t = 0; t < 2; t++)
        for (int s = 0; s < 512; s++)
          run_burst(s, t, code);

    // R7: restart mid-burst
    @(negedge clk);
    drive_cmd(10, 0, 3);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    drive_cmd(100, 1, 2);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int n = 0; n < 4; n++) begin
      chk(col_valid && int'(col) == exp_col(100, 1, 2, n), "R7 restart column",
          int'(col), exp_col(100, 1, 2, n));
      chk(col_last == (n == 3), "R7 restart last", int'(col_last), int'(n == 3));
      @(negedge clk);
    end
    chk(col_valid == 1'b0, "R7 restart ends", int'(col_valid), 0);

    // R8: stop mid-burst
    drive_cmd(40, 0, 3);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(col_valid == 1'b0, "R8 stop clears", int'(col_valid), 0);
    @(negedge clk);
    chk(col_valid == 1'b0 && col_last == 1'b0, "R8 stays idle", int'(col_valid), 0);

    // R8: stop while idle has no effect
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(col_valid == 1'b0, "R8 idle stop", int'(col_valid), 0);

    // R8: command and stop together, command wins
    drive_cmd(77, 1, 1);
    stop = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    stop = 1'b0;
    chk(col_valid && int'(col) == 77, "R8 command beats stop", int'(col), 77);
    @(negedge clk);
    chk(col_valid && col_last && int'(col) == exp_col(77, 1, 1, 1), "R8 second beat",
        int'(col), exp_col(77, 1, 1, 1));
    @(negedge clk);
    chk(col_valid == 1'b0, "R8 burst ends", int'(col_valid), 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule